// File: doc/BRIEF.md
# Translation Cache with Least-Recently-Used Refill

This block translates logical addresses into physical addresses through a small fully associative translation cache that sits in front of an on-chip page table. The logical address is split into a page number in its upper bits and a byte offset in its lower bits. The cache is searched for the page number. On a hit, the cached frame number is joined with the offset and returned on the next cycle. On a miss, the block spends one more cycle reading the page table. If the entry is resident, the block installs the mapping, replacing the least recently used slot when every slot is occupied, and returns the translation. If the entry is not resident, it reports a page fault.

Software fills the page table one 32-bit entry at a time. A write to an entry also removes any cached copy of that page. A flush pulse empties the whole cache in one cycle. Two free-running counters expose the numbers of hits and misses. A client presents one request at a time and holds off while the busy output is high.

Top module: `tlb_lru_refill`

## Requirements
- R1: The page number is `req_vaddr[VA_W-1:OFF_W]` and the offset is `req_vaddr[OFF_W-1:0]` (OFF_W = 10, i.e. 1024-byte pages). A translated address equals frame × 1024 + offset, which is `{frame, offset}`.
- R2: A request accepted while idle that finds its page cached produces `resp_valid` with `resp_hit` = 1 and the translated address in the cycle after acceptance.
- R3: A request that misses raises `busy` for exactly one cycle. The response follows one cycle after that with `resp_hit` = 0. A resident entry is then cached, so the next access to the same page hits, and a page is never cached twice.
- R4: A request presented while `busy` is high is ignored. It produces no response and changes no counter.
- R5: Recency is refreshed on every hit and every install. When all 4 slots are full, an install replaces the least recently used page. With accesses to pages 0, 1, 0, 2, 3, 4, page 1 is evicted rather than page 0.
- R6: A page-table entry uses bit 31 as the resident flag and bits 23:0 as the frame. Bits 30:24 do not affect translation. If the resident flag is 0, the miss response has `resp_fault` = 1 and `resp_paddr` = 0, and nothing is cached, so a repeat access also misses and faults.
- R7: `hit_count` increments once per hit response. `miss_count` increments once per miss response, and faulting misses are included.
- R8: A `flush` pulse invalidates every cached mapping in one cycle.
- R9: Writing a page-table entry invalidates any cached mapping of that page, so the next access misses and returns the new frame.
- R10: A flush that lands in the same cycle as a miss completes still lets that response carry the table's translation, but leaves the page uncached.
- R11: A page-table write to the page being fetched, in the cycle the miss completes, is seen by that miss. The new frame is both returned and cached.
- R12: After reset, `busy`, `resp_valid` and both counters are 0, and every page-table entry reads as non-resident.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_vaddr | input | VA_W | Logical address |
| busy | output | 1 | Miss in progress; requests are ignored |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_hit | output | 1 | Response came from the cache |
| resp_fault | output | 1 | Page not resident |
| resp_paddr | output | 24+OFF_W | Physical address, 0 on fault |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | VA_W-OFF_W | Page-table entry index |
| pt_wdata | input | 32 | Page-table entry value |
| flush | input | 1 | Invalidate all cached mappings |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses, faults included |

## Verification
Two functions can fall in the same cycle as a miss install: a cache flush and a page-table write to the page being fetched. The bench provokes each one by driving the side action during the single busy cycle of a miss, so that it meets the completing refill at the same clock edge. A flush collision is judged by a normal response followed by a repeat miss on that page. A table-write collision is judged by a response that carries the newly written frame, followed by a hit on that same frame.

// File: rtl/tlb_pkg.sv
// Package: shared constants and types of the translation cache.
// Assumes a 32-bit page-table entry with the resident flag in the top bit
// and the frame number in the low 24 bits.
package tlb_pkg;
    localparam int PTE_W     = 32;
    localparam int PTE_V_BIT = 31;
    localparam int FRAME_W   = 24;

    // Trimmed page-table entry as stored: resident flag and frame only.
    typedef struct packed {
        logic               v;
        logic [FRAME_W-1:0] frame;
    } pte_store_t;

    // Controller state: waiting for a request, or reading the table.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_t;
endpackage

// File: rtl/tlb_page_table.sv
// Module: register-array page table, one entry per page.
// Holds only the resident flag and frame of each entry. The read port is
// combinational and forwards a same-cycle write to the entry being read.
// Assumes a single write port driven by software.
module tlb_page_table
    import tlb_pkg::*;
#(
    parameter int PN_W      = 4,
    parameter int NUM_PAGES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PN_W-1:0]  wr_idx,
    input  logic [PTE_W-1:0] wr_data,
    input  logic [PN_W-1:0]  rd_idx,
    output pte_store_t       rd_data
);
    pte_store_t tbl_q [NUM_PAGES];
    pte_store_t wr_trim;
    logic       unused_pte_bits;

    // Keep only the fields translation depends on.
    assign wr_trim.v       = wr_data[PTE_V_BIT];
    assign wr_trim.frame   = wr_data[FRAME_W-1:0];
    assign unused_pte_bits = ^wr_data[PTE_V_BIT-1:FRAME_W];

    for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_entry
        // Store one entry; it is cleared to non-resident on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[gi] <= '0;
            end else if (wr_en && wr_idx == PN_W'(gi)) begin
                tbl_q[gi] <= wr_trim;
            end
        end
    end

    // Read with forwarding so a walk sees a write from the same cycle.
    always_comb begin
        if (wr_en && wr_idx == rd_idx) begin
            rd_data = wr_trim;
        end else begin
            rd_data = tbl_q[rd_idx];
        end
    end

    // A write must be visible on the next read of the same entry.
    AST_PT_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$isunknown(wr_data)) |=> (tbl_q[$past(wr_idx)].v == $past(wr_data[PTE_V_BIT]))); // R9
endmodule

// File: rtl/tlb_cam.sv
// Module: fully associative store of page-to-frame mappings.
// Looks up a page combinationally. Clearing has a fixed priority per slot:
// flush, then install, then invalidation of a matching page.
// Assumes the controller never installs a page that is already cached.
module tlb_cam #(
    parameter int ENTRIES = 4,
    parameter int PN_W    = 4,
    parameter int FRAME_W = 24,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PN_W-1:0]    lk_vpn,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_slot,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               full,
    output logic [IDX_W-1:0]   free_slot,
    input  logic               flush,
    input  logic               inv_en,
    input  logic [PN_W-1:0]    inv_vpn,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_slot,
    input  logic [PN_W-1:0]    ins_vpn,
    input  logic [FRAME_W-1:0] ins_frame
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [PN_W-1:0]    vpn_q   [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        // Maintain one slot: flush wins, then install, then invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[gi] <= 1'b0;
                vpn_q[gi]   <= '0;
                frame_q[gi] <= '0;
            end else if (flush) begin
                valid_q[gi] <= 1'b0;
            end else if (ins_en && ins_slot == IDX_W'(gi)) begin
                valid_q[gi] <= 1'b1;
                vpn_q[gi]   <= ins_vpn;
                frame_q[gi] <= ins_frame;
            end else if (inv_en && vpn_q[gi] == inv_vpn) begin
                valid_q[gi] <= 1'b0;
            end
        end

        assign match[gi] = valid_q[gi] && (vpn_q[gi] == lk_vpn);
    end

    assign lk_hit = |match;
    assign full   = &valid_q;

    // Encode the matching slot and pick its frame.
    always_comb begin
        lk_slot  = '0;
        lk_frame = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_slot  = IDX_W'(i);
                lk_frame = frame_q[i];
            end
        end
    end

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_slot = IDX_W'(i);
            end
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R8
    AST_INSTALL_NOT_FULL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush) |=> valid_q[$past(ins_slot)]); // R3
endmodule

// File: rtl/tlb_lru.sv
// Module: true least-recently-used tracking by per-slot age.
// Ages form a permutation of 0..ENTRIES-1. The touched slot becomes age 0,
// and slots younger than it age by one. The oldest slot has the top age.
// Assumes ENTRIES >= 2.
module tlb_lru #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_slot,
    output logic [IDX_W-1:0] oldest_slot
);
    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [IDX_W-1:0]   touch_age;
    logic [ENTRIES-1:0] newest_vec;

    assign touch_age = age_q[touch_slot];

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_age
        // Update one slot's age on a touch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[gi] <= IDX_W'(gi);
            end else if (touch_en) begin
                if (touch_slot == IDX_W'(gi)) begin
                    age_q[gi] <= '0;
                end else if (age_q[gi] < touch_age) begin
                    age_q[gi] <= age_q[gi] + 1'b1;
                end
            end
        end

        assign newest_vec[gi] = (age_q[gi] == '0);
    end

    // Select the slot holding the top age.
    always_comb begin
        oldest_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == AGE_MAX) begin
                oldest_slot = IDX_W'(i);
            end
        end
    end

    AST_SINGLE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(newest_vec) == 1); // R5
    AST_TOUCHED_IS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (age_q[$past(touch_slot)] == '0)); // R5
endmodule

// File: rtl/tlb_lru_refill.sv
// Module: translation cache top with automatic page-table refill.
// Idle: a request is looked up. A hit answers next cycle. A miss latches
// the page and offset and enters a one-cycle walk, which reads the page
// table, installs a resident entry (empty slot first, otherwise the least
// recently used slot) and answers. A non-resident entry answers as a fault.
// Assumes the client keeps at most one request outstanding.
module tlb_lru_refill
    import tlb_pkg::*;
#(
    parameter int VA_W    = 14,
    parameter int OFF_W   = 10,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    output logic                       busy,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic                       resp_fault,
    output logic [FRAME_W+OFF_W-1:0]   resp_paddr,
    input  logic                       pt_we,
    input  logic [VA_W-OFF_W-1:0]      pt_idx,
    input  logic [PTE_W-1:0]           pt_wdata,
    input  logic                       flush,
    output logic [CNT_W-1:0]           hit_count,
    output logic [CNT_W-1:0]           miss_count
);
    localparam int PN_W      = VA_W - OFF_W;
    localparam int NUM_PAGES = 1 << PN_W;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int PA_W      = FRAME_W + OFF_W;

    walk_state_t        st_q;
    logic [PN_W-1:0]    walk_vpn_q;
    logic [OFF_W-1:0]   walk_off_q;
    logic               accept;
    logic               walking;
    logic [PN_W-1:0]    req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_slot;
    logic [FRAME_W-1:0] lk_frame;
    logic               cam_full;
    logic [IDX_W-1:0]   cam_free;
    logic [IDX_W-1:0]   lru_oldest;
    pte_store_t         pt_rd;
    logic               ins_en;
    logic [IDX_W-1:0]   ins_slot;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_slot;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];
    assign walking = (st_q == ST_WALK);
    assign accept  = req_valid && (st_q == ST_IDLE);
    assign busy    = walking;

    // Install on a resident walk, into a free slot before evicting.
    assign ins_en     = walking && pt_rd.v;
    assign ins_slot   = cam_full ? lru_oldest : cam_free;
    assign touch_en   = (accept && lk_hit) || ins_en;
    assign touch_slot = ins_en ? ins_slot : lk_slot;

    tlb_page_table #(
        .PN_W      (PN_W),
        .NUM_PAGES (NUM_PAGES)
    ) u_pt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pt_we),
        .wr_idx  (pt_idx),
        .wr_data (pt_wdata),
        .rd_idx  (walk_vpn_q),
        .rd_data (pt_rd)
    );

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .PN_W    (PN_W),
        .FRAME_W (FRAME_W),
        .IDX_W   (IDX_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vpn),
        .lk_hit    (lk_hit),
        .lk_slot   (lk_slot),
        .lk_frame  (lk_frame),
        .full      (cam_full),
        .free_slot (cam_free),
        .flush     (flush),
        .inv_en    (pt_we),
        .inv_vpn   (pt_idx),
        .ins_en    (ins_en),
        .ins_slot  (ins_slot),
        .ins_vpn   (walk_vpn_q),
        .ins_frame (pt_rd.frame)
    );

    tlb_lru #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_en    (touch_en),
        .touch_slot  (touch_slot),
        .oldest_slot (lru_oldest)
    );

    // Sequence idle and walk states; latch the missing page and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            walk_vpn_q <= '0;
            walk_off_q <= '0;
        end else if (accept && !lk_hit) begin
            st_q       <= ST_WALK;
            walk_vpn_q <= req_vpn;
            walk_off_q <= req_off;
        end else if (walking) begin
            st_q <= ST_IDLE;
        end
    end

    // Register the response of a hit or of a finished walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
        end else if (walking) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_fault <= !pt_rd.v;
            resp_paddr <= pt_rd.v ? {pt_rd.frame, walk_off_q} : '0;
        end else if (accept && lk_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_fault <= 1'b0;
            resp_paddr <= {lk_frame, req_off};
        end else begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
        end
    end

    // Count hits at lookup and misses at walk completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (accept && lk_hit) begin
                hit_count <= hit_count + 1'b1;
            end
            if (walking) begin
                miss_count <= miss_count + 1'b1;
            end
        end
    end

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (resp_valid && resp_hit)); // R2
    AST_MISS_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> (busy && !resp_valid)); // R3
    AST_WALK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && resp_valid && !resp_hit)); // R3
    AST_BUSY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hit_count)); // R4
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (!resp_hit && resp_paddr == '0)); // R6
    AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1))); // R7
    AST_MISS_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (miss_count == $past(miss_count) + CNT_W'(1))); // R7
endmodule

// File: tb/tb_tlb_lru_refill.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected responses, a monitor pops
// and compares them whenever the design answers.
module tb_tlb_lru_refill;
    localparam int VA_W  = 14;
    localparam int OFF_W = 10;
    localparam int PN_W  = VA_W - OFF_W;
    localparam int PA_W  = 24 + OFF_W;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             busy;
    logic             resp_valid;
    logic             resp_hit;
    logic             resp_fault;
    logic [PA_W-1:0]  resp_paddr;
    logic             pt_we = 1'b0;
    logic [PN_W-1:0]  pt_idx = '0;
    logic [31:0]      pt_wdata = '0;
    logic             flush = 1'b0;
    logic [CNT_W-1:0] hit_count;
    logic [CNT_W-1:0] miss_count;

    typedef struct {
        logic [PA_W-1:0] pa;
        logic            flt;
        logic            hit;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   exp_hits = 0;
    int   exp_miss = 0;
    bit   done     = 1'b0;

    always #2 clk = ~clk;

    tlb_lru_refill dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_fault (resp_fault),
        .resp_paddr (resp_paddr),
        .pt_we      (pt_we),
        .pt_idx     (pt_idx),
        .pt_wdata   (pt_wdata),
        .flush      (flush),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [VA_W-1:0] va(input int page, input int off);
        return VA_W'(page * 1024 + off);
    endfunction

    // Queue the expected answer for one access.
    task automatic push_exp(input logic [VA_W-1:0] a, input bit h, input bit f,
                            input logic [23:0] frame, input string tag);
        exp_t e;
        e.pa  = f ? '0 : {frame, a[OFF_W-1:0]};
        e.flt = f;
        e.hit = h;
        e.tag = tag;
        q.push_back(e);
        if (h) exp_hits++;
        else   exp_miss++;
    endtask

    // Drive one request and wait until the block is idle again.
    task automatic access(input int page, input int off, input bit h, input bit f,
                          input logic [23:0] frame, input string tag);
        logic [VA_W-1:0] a;
        a = va(page, off);
        push_exp(a, h, f, frame, tag);
        req_valid = 1'b1;
        req_vaddr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic pt_write(input int page, input logic [31:0] data);
        pt_we    = 1'b1;
        pt_idx   = PN_W'(page);
        pt_wdata = data;
        @(negedge clk);
        pt_we = 1'b0;
    endtask

    // Miss with a side action in its busy cycle: 0 flush, 1 table write.
    task automatic collide(input int page, input int off, input int kind,
                           input logic [23:0] frame, input logic [31:0] wdata, input string tag);
        logic [VA_W-1:0] a;
        a = va(page, off);
        push_exp(a, 1'b0, 1'b0, frame, tag);
        req_valid = 1'b1;
        req_vaddr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R3 busy during miss", busy, 1);
        if (kind == 0) begin
            flush = 1'b1;
        end else begin
            pt_we    = 1'b1;
            pt_idx   = PN_W'(page);
            pt_wdata = wdata;
        end
        @(negedge clk);
        flush = 1'b0;
        pt_we = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Monitor: compare each response against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4 unexpected response", resp_paddr, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(resp_hit == e.hit, {e.tag, " hit flag"}, resp_hit, e.hit);
                chk(resp_fault == e.flt, {e.tag, " fault flag"}, resp_fault, e.flt);
                chk(resp_paddr == e.pa, {e.tag, " paddr"}, resp_paddr, e.pa);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(busy == 1'b0, "R12 busy after reset", busy, 0);
        chk(resp_valid == 1'b0, "R12 resp_valid after reset", resp_valid, 0);
        chk(hit_count == '0, "R12 hit_count after reset", hit_count, 0);
        chk(miss_count == '0, "R12 miss_count after reset", miss_count, 0);
        access(3, 12'h012, 1'b0, 1'b1, 24'h0, "R12 empty table faults");

        // Fill the table: pages 0..5 resident, page 6 non-resident with R/W/X set.
        for (int p = 0; p < 6; p++) begin
            pt_write(p, {1'b1, 7'h00, 24'hA000 + 24'(p)});
        end
        pt_write(6, 32'h7F00_00FF);

        // R5 recency order with R1 address composition at varied offsets.
        access(0, 0,     1'b0, 1'b0, 24'hA000, "R1 R3 page0 miss");
        access(1, 1023,  1'b0, 1'b0, 24'hA001, "R1 page1 top offset miss");
        access(0, 500,   1'b1, 1'b0, 24'hA000, "R2 page0 hit");
        access(2, 700,   1'b0, 1'b0, 24'hA002, "R3 page2 miss");
        access(3, 1,     1'b0, 1'b0, 24'hA003, "R3 page3 miss");
        access(4, 77,    1'b0, 1'b0, 24'hA004, "R5 page4 evicts");
        access(0, 9,     1'b1, 1'b0, 24'hA000, "R5 page0 kept");
        access(1, 5,     1'b0, 1'b0, 24'hA001, "R5 page1 evicted");
        access(3, 300,   1'b1, 1'b0, 24'hA003, "R5 page3 hit");

        // R6 non-resident entry faults and is not cached.
        access(6, 40, 1'b0, 1'b1, 24'h0, "R6 fault first");
        access(6, 41, 1'b0, 1'b1, 24'h0, "R6 fault again");
        chk(int'(hit_count) == exp_hits, "R7 hit_count", hit_count, exp_hits);
        chk(int'(miss_count) == exp_miss, "R7 miss_count", miss_count, exp_miss);

        // R9 table write invalidates the cached copy.
        pt_write(0, {1'b1, 7'h70, 24'hB000});
        access(0, 8, 1'b0, 1'b0, 24'hB000, "R9 rewritten page misses");
        access(0, 8, 1'b1, 1'b0, 24'hB000, "R9 new frame hits");

        // R8 flush empties the cache.
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        access(3, 2, 1'b0, 1'b0, 24'hA003, "R8 after flush misses");
        access(3, 2, 1'b1, 1'b0, 24'hA003, "R8 refilled hits");

        // R10 flush colliding with install.
        collide(2, 33, 0, 24'hA002, 32'h0, "R10 flush at install");
        access(2, 34, 1'b0, 1'b0, 24'hA002, "R10 page left uncached");

        // R11 table write colliding with the walk of the same page.
        collide(4, 600, 1, 24'hC004, {1'b1, 7'h00, 24'hC004}, "R11 write during walk");
        access(4, 601, 1'b1, 1'b0, 24'hC004, "R11 new frame cached");

        // R4 a request held during busy is ignored.
        push_exp(va(5, 3), 1'b0, 1'b0, 24'hA005, "R4 miss page5");
        req_valid = 1'b1;
        req_vaddr = va(5, 3);
        @(negedge clk);
        req_vaddr = va(4, 3);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0, "R4 single response", q.size(), 0);
        chk(int'(hit_count) == exp_hits, "R4 hit_count unchanged", hit_count, exp_hits);

        chk(int'(hit_count) == exp_hits, "R7 final hit_count", hit_count, exp_hits);
        chk(int'(miss_count) == exp_miss, "R7 final miss_count", miss_count, exp_miss);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule